// File: doc/BRIEF.md
# Prescaled Auto-Reload Countdown Timer

This block is a countdown timer meant to sit beside a processor core. Software programs four registers through a plain register port: control, scale, period and count. While the timer runs, count drops by one once every scale+1 clock cycles. When count steps from one to zero, the timer raises a sticky flag and drives a level interrupt. If reload is enabled, the period value is copied into count and the next interval starts at once. If reload is off, the counter parks at zero until software writes count again.

The first interval is set by whatever was last written to count, and it can differ from the period. Later intervals use the period. A low-power bit, or a cleared enable bit, freezes both the counter and the prescaler phase without losing any register contents. Software acknowledges an interrupt by writing one to the flag's bit position in the control register.

A four-state machine governs counting: OFF (enable clear), SLEEP (enabled with low-power set), RUN (enabled, awake, count nonzero) and DONE (enabled, awake, count zero). The transitions are ENABLE (OFF to RUN or DONE), DISABLE (any state to OFF), DOZE (RUN or DONE to SLEEP), WAKE (SLEEP to RUN or DONE), EXPIRE (RUN to DONE at a terminal count without reload, or on a write of zero) and ARM (DONE to RUN on a nonzero count write). The next state is worked out from the register values the same clock edge will store, so the state always matches the registers.

Top module: `rct_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While running with scale value s, count drops by exactly one every s+1 clock cycles.
- R3: After count is written with N while the timer runs, the terminal event (count going from 1 to 0) lands N*(s+1) cycles after the write edge, and `irq` is high from the cycle after it.
- R4: With reload enabled (control bit 2), the terminal event copies period P into count, and the next event follows P*(s+1) cycles after the previous one.
- R5: With reload disabled, count stays at zero after the terminal event and no further event occurs until count is written.
- R6: The sticky flag (control bit 3) stays set until control is written with bit 3 equal to 1; a control write with bit 3 equal to 0 leaves it set.
- R7: A terminal event in the same cycle as a flag clear leaves the flag set.
- R8: Setting low-power (control bit 1) freezes count and the prescaler phase, and keeps scale and period unchanged; counting resumes from the same phase on wake.
- R9: `irq` equals the sticky flag gated by enable (control bit 0): clearing enable drops `irq` while the flag stays readable, and re-enabling raises it again.
- R10: Writing count or scale restarts the prescaler phase at zero.
- R11: The register addresses are 0 control, 1 scale, 2 period and 3 count; the read data shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select: 0 control, 1 scale, 2 period, 3 count |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data of the addressed register (combinational) |
| irq | output | 1 | Level interrupt: sticky flag AND enable |

## Verification
Two functions can fall in the same cycle: a terminal event and a software write of one to the flag bit. The bench lets one event pass unacknowledged, then times a clear so that it lands exactly on the edge of the next reload event. It judges the outcome by reading the control register afterwards and expecting the flag still set, and then shows that a clear one cycle later does work. The same care covers a scale write that lands while the prescaler is partway through its phase: the position of the next decrement shows whether the phase restarted.

// File: rtl/rct_pkg.sv
package rct_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } rct_state_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_SCALE  = 2'd1;
    localparam logic [1:0] ADDR_PERIOD = 2'd2;
    localparam logic [1:0] ADDR_COUNT  = 2'd3;

    localparam int BIT_EN     = 0;
    localparam int BIT_LP     = 1;
    localparam int BIT_RELOAD = 2;
    localparam int BIT_FLAG   = 3;

endpackage

// File: rtl/rct_prescale.sv
module rct_prescale #(
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               clr,
    input  logic [SCALE_W-1:0] scale,
    output logic               tick
);

    logic [SCALE_W-1:0] phase_q;

    assign tick = run && (phase_q == scale);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr) begin
            phase_q <= '0;
        end else if (run) begin
            if (tick) phase_q <= '0;
            else      phase_q <= phase_q + 1'b1;
        end
    end

    // R10: a write of count or scale restarts the phase
    p_phase_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (phase_q == '0));

    // R8: a halted timer keeps its prescaler phase
    p_phase_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(phase_q));

endmodule

// File: rtl/rct_ctrl_regs.sv
module rct_ctrl_regs
    import rct_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int SCALE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [CNT_W-1:0]   reg_wdata,
    input  logic               evt,
    output logic               en_q,
    output logic               lp_q,
    output logic               reload_q,
    output logic               flag_q,
    output logic               en_d,
    output logic               lp_d,
    output logic               scale_wr,
    output logic [SCALE_W-1:0] scale_q,
    output logic [CNT_W-1:0]   period_q
);

    logic ctrl_wr;
    logic period_wr;
    logic flag_clr;
    logic reload_d;
    logic flag_d;

    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CTRL);
    assign scale_wr  = reg_wr && (reg_addr == ADDR_SCALE);
    assign period_wr = reg_wr && (reg_addr == ADDR_PERIOD);
    assign flag_clr  = ctrl_wr && reg_wdata[BIT_FLAG];

    always_comb begin
        en_d     = ctrl_wr ? reg_wdata[BIT_EN]     : en_q;
        lp_d     = ctrl_wr ? reg_wdata[BIT_LP]     : lp_q;
        reload_d = ctrl_wr ? reg_wdata[BIT_RELOAD] : reload_q;
        if (evt)           flag_d = 1'b1;
        else if (flag_clr) flag_d = 1'b0;
        else               flag_d = flag_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            lp_q     <= 1'b0;
            reload_q <= 1'b0;
            flag_q   <= 1'b0;
            scale_q  <= '0;
            period_q <= '0;
        end else begin
            en_q     <= en_d;
            lp_q     <= lp_d;
            reload_q <= reload_d;
            flag_q   <= flag_d;
            if (scale_wr)  scale_q  <= reg_wdata[SCALE_W-1:0];
            if (period_wr) period_q <= reg_wdata;
        end
    end

    // R6: the flag survives anything but a one written to its bit
    p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_clr) |=> flag_q);

    // R7: an event always leaves the flag set, even against a clear
    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_q);

    // R8: scale and period hold unless written
    p_scale_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !scale_wr |=> $stable(scale_q));

endmodule

// File: rtl/rct_count_fsm.sv
module rct_count_fsm
    import rct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_d,
    input  logic             lp_d,
    input  logic             reload_q,
    input  logic [CNT_W-1:0] period_q,
    input  logic             count_wr,
    input  logic [CNT_W-1:0] count_wdata,
    input  logic             tick,
    output logic [CNT_W-1:0] count_q,
    output logic             run,
    output logic             evt
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    rct_state_e       state_q;
    rct_state_e       state_d;
    logic [CNT_W-1:0] count_d;
    logic             awake_d;
    logic             live_d;

    // outputs of the current state
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_OFF:   run = 1'b0;
            ST_SLEEP: run = 1'b0;
            ST_RUN:   run = 1'b1;
            ST_DONE:  run = 1'b0;
        endcase
    end

    assign evt = tick && (count_q == ONE) && !count_wr;

    always_comb begin
        if (count_wr)     count_d = count_wdata;
        else if (evt)     count_d = reload_q ? period_q : '0;
        else if (tick)    count_d = count_q - ONE;
        else              count_d = count_q;
    end

    assign awake_d = en_d && !lp_d;
    assign live_d  = (count_d != '0);

    // transitions: ENABLE, DISABLE, DOZE, WAKE, EXPIRE, ARM
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_d && lp_d)  state_d = ST_SLEEP;
                else if (awake_d)  state_d = live_d ? ST_RUN : ST_DONE; // ENABLE
            end
            ST_SLEEP: begin
                if (!en_d)         state_d = ST_OFF;                    // DISABLE
                else if (!lp_d)    state_d = live_d ? ST_RUN : ST_DONE; // WAKE
            end
            ST_RUN: begin
                if (!en_d)         state_d = ST_OFF;                    // DISABLE
                else if (lp_d)     state_d = ST_SLEEP;                  // DOZE
                else if (!live_d)  state_d = ST_DONE;                   // EXPIRE
            end
            ST_DONE: begin
                if (!en_d)         state_d = ST_OFF;                    // DISABLE
                else if (lp_d)     state_d = ST_SLEEP;                  // DOZE
                else if (live_d)   state_d = ST_RUN;                    // ARM
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // R2: a tick above the terminal value removes exactly one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !count_wr && (count_q > ONE)) |=> (count_q == $past(count_q) - ONE));

    // R4: the terminal event with reload loads the period
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && reload_q) |=> (count_q == $past(period_q)));

    // R5: a parked counter stays at zero until written
    p_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !count_wr) |=> (count_q == '0));

    // R8: without a write, a halted counter holds
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !count_wr) |=> $stable(count_q));

endmodule

// File: rtl/rct_timer.sv
module rct_timer
    import rct_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int SCALE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             irq
);

    localparam int CTRL_W = BIT_FLAG + 1;

    logic               en_q, lp_q, reload_q, flag_q;
    logic               en_d, lp_d;
    logic               scale_wr, count_wr;
    logic [SCALE_W-1:0] scale_q;
    logic [CNT_W-1:0]   period_q;
    logic [CNT_W-1:0]   count_q;
    logic               run, tick, evt;

    assign count_wr = reg_wr && (reg_addr == ADDR_COUNT);

    rct_ctrl_regs #(.CNT_W(CNT_W), .SCALE_W(SCALE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .evt       (evt),
        .en_q      (en_q),
        .lp_q      (lp_q),
        .reload_q  (reload_q),
        .flag_q    (flag_q),
        .en_d      (en_d),
        .lp_d      (lp_d),
        .scale_wr  (scale_wr),
        .scale_q   (scale_q),
        .period_q  (period_q)
    );

    rct_prescale #(.SCALE_W(SCALE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (count_wr || scale_wr),
        .scale (scale_q),
        .tick  (tick)
    );

    rct_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_d        (en_d),
        .lp_d        (lp_d),
        .reload_q    (reload_q),
        .period_q    (period_q),
        .count_wr    (count_wr),
        .count_wdata (reg_wdata),
        .tick        (tick),
        .count_q     (count_q),
        .run         (run),
        .evt         (evt)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL:   reg_rdata[CTRL_W-1:0] = {flag_q, reload_q, lp_q, en_q};
            ADDR_SCALE:  reg_rdata[SCALE_W-1:0] = scale_q;
            ADDR_PERIOD: reg_rdata = period_q;
            ADDR_COUNT:  reg_rdata = count_q;
        endcase
    end

    assign irq = flag_q && en_q;

    // R9: dropping enable takes the interrupt down
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_q) |-> !irq);

endmodule

// File: tb/tb_rct_timer.sv
module tb_rct_timer;

    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [CNT_W-1:0] reg_wdata = '0;
    logic [CNT_W-1:0] reg_rdata;
    logic             irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    rct_timer #(.CNT_W(CNT_W), .SCALE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // {scale, period, count, reload}
    localparam int NV = 6;
    localparam logic [63:0] VECS [NV] = '{
        {16'd0, 16'd8,  16'd16, 16'd1},
        {16'd2, 16'd5,  16'd4,  16'd1},
        {16'd1, 16'd3,  16'd7,  16'd1},
        {16'd3, 16'd2,  16'd1,  16'd1},
        {16'd0, 16'd32, 16'd64, 16'd1},
        {16'd1, 16'd0,  16'd6,  16'd0}
    };

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_irq(output int k);
        k = 0;
        while (!irq && k < 5000) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        summary();
    end

    initial begin
        logic [CNT_W-1:0] v;
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], v);
            check("R1 reset reg", v, 0);
        end
        check("R1 reset irq", irq, 0);

        // table of vectors: R3, R4, R5, R11
        for (int i = 0; i < NV; i++) begin
            int s, p, n, ar;
            s  = int'(VECS[i][63:48]);
            p  = int'(VECS[i][47:32]);
            n  = int'(VECS[i][31:16]);
            ar = int'(VECS[i][15:0]);
            wr(2'd0, 32'h8);
            wr(2'd3, 0);
            wr(2'd1, s);
            wr(2'd2, p);
            wr(2'd0, 32'h1 | (ar << 2));
            rd(2'd2, v);
            check("R11 period readback", v, p);
            rd(2'd1, v);
            check("R11 scale readback", v, s);
            wr(2'd3, n);
            wait_irq(k);
            check("R3 first interval", k, n * (s + 1));
            if (ar != 0) begin
                wr(2'd0, 32'hD);
                wait_irq(k);
                check("R4 reload interval", k + 1, p * (s + 1));
            end else begin
                rd(2'd3, v);
                check("R5 parked count", v, 0);
                wr(2'd0, 32'h9);
                repeat (40) @(negedge clk);
                check("R5 no second event", irq, 0);
                rd(2'd3, v);
                check("R5 still zero", v, 0);
            end
        end

        // R2 and R10: decrement spacing and phase restart
        wr(2'd0, 32'h8);
        wr(2'd3, 0);
        wr(2'd1, 2);
        wr(2'd0, 32'h1);
        wr(2'd3, 10);
        @(negedge clk); @(negedge clk);
        rd(2'd3, v); check("R2 count before tick", v, 10);
        @(negedge clk);
        rd(2'd3, v); check("R2 count after s+1", v, 9);
        wr(2'd1, 3);
        repeat (3) @(negedge clk);
        rd(2'd3, v); check("R10 no early tick", v, 9);
        @(negedge clk);
        rd(2'd3, v); check("R10 tick after restart", v, 8);

        // R6 and R7: flag clear against a coincident event
        wr(2'd0, 32'h8);
        wr(2'd3, 0);
        wr(2'd1, 0);
        wr(2'd2, 5);
        wr(2'd0, 32'h5);
        wr(2'd3, 5);                  // events at E5, E10, E15
        repeat (6) @(negedge clk);
        wr(2'd0, 32'h5);              // lands on E7, bit 3 zero
        rd(2'd0, v); check("R6 flag kept on zero write", v[3], 1);
        repeat (2) @(negedge clk);
        wr(2'd0, 32'hD);              // lands on E10 with the event
        rd(2'd0, v); check("R7 event beats clear", v[3], 1);
        wr(2'd0, 32'hD);              // lands on E11
        rd(2'd0, v); check("R6 clear by one", v[3], 0);
        check("R6 irq low after clear", irq, 0);

        // R9: enable gates the interrupt
        wait_irq(k);
        check("R9 irq raised", irq, 1);
        wr(2'd0, 32'h4);
        check("R9 irq gated off", irq, 0);
        rd(2'd0, v); check("R9 flag still readable", v[3], 1);
        wr(2'd0, 32'h5);
        check("R9 irq back", irq, 1);

        // R8: low-power freeze keeps count, phase and registers
        wr(2'd0, 32'h8);
        wr(2'd3, 0);
        wr(2'd1, 3);
        wr(2'd2, 9);
        wr(2'd0, 32'h1);
        wr(2'd3, 10);
        @(negedge clk);
        wr(2'd0, 32'h3);
        repeat (7) @(negedge clk);
        rd(2'd3, v); check("R8 frozen count", v, 10);
        rd(2'd1, v); check("R8 scale kept", v, 3);
        rd(2'd2, v); check("R8 period kept", v, 9);
        wr(2'd0, 32'h1);
        @(negedge clk);
        rd(2'd3, v); check("R8 phase kept before tick", v, 10);
        @(negedge clk);
        rd(2'd3, v); check("R8 resumes from phase", v, 9);

        summary();
    end

endmodule